// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external microcontroller read and write an 8-bit register file through a four-wire serial link. The link has a serial clock, an active-low chip select, a data input and a data output. Each transaction is framed by chip select. There is no slave address: the device is selected by chip select alone.

A frame has 24 bits, all sent most significant bit first:

- one operation flag;
- a 15-bit address field, of which only the low 10 bits reach the register file;
- one data byte.

On the register side the port offers four signals:

- a registered address;
- a one-cycle write strobe with its data;
- a one-cycle read request;
- a read-data input, which the port samples one clock after the request.

All link inputs are oversampled in the system clock domain, so the register file needs no clock-domain crossing. Two constraints apply:

- Each half period of the serial clock must last at least six system clocks.
- The serial clock idles low.

The output pin is driven only while read data is returned. The port gives a data bit and an output enable, and an external pad buffer turns them into a high-impedance pin.

Top module: `spi_reg_port`

## Requirements
- R1: While `cs_n` is high, serial clock edges cause no strobe and the frame bit counter stays at zero. A falling `cs_n` starts a new frame at bit zero, and a rising `cs_n` ends it.
- R2: The first bit sampled in a frame selects the operation: 1 means read and 0 means write.
- R3: The 15-bit address field follows the operation bit, MSB first. Its top five bits are ignored, and `reg_addr` carries its low 10 bits.
- R4: On a write, the 8 data bits follow the address MSB first. After the 24th rising `sclk` edge, exactly one single-cycle `reg_wr` pulse is issued, with `reg_wdata` equal to those bits.
- R5: If `cs_n` rises before the 24th rising `sclk` edge of a write, no `reg_wr` is issued.
- R6: On a read, exactly one single-cycle `reg_rd` pulse is issued after the 16th rising `sclk` edge. `reg_rdata` is taken in the clock cycle after that pulse.
- R7: Read data appears on `sdo` MSB first. Each bit changes after a falling `sclk` edge and is valid at the following rising edge. `sdi` is ignored during the data phase of a read.
- R8: `sdo_oe` is low during the flag and address phases and throughout a write. It rises at the first falling edge of a read's data phase and stays high until `cs_n` rises.
- R9: A synchronous active-high `rst` clears `reg_wr`, `reg_rd`, `sdo_oe` and `sdo` at the next clock edge.
- R10: Rising `sclk` edges beyond the 24th in one frame are ignored, and they produce no second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low chip select that frames a transaction |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial read data toward the pad buffer |
| sdo_oe | output | 1 | Pad output enable; the pin is high-impedance when low |
| reg_addr | output | 10 | Register address (low bits of the address field) |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | 8 | Register contents, valid one clock after `reg_rd` |

## Verification
Two cases cannot be reached from a clean frame: a write that chip select cuts short after some of its data bits, and a frame that carries more than 24 clock pulses. The bench master therefore takes a bit count that differs from the frame length. It ends one write after 20 bits and then reads the same register back to show the old value survived. It runs another write to 28 bits and counts the strobes. Every read uses an address whose top five bits differ from those used in the matching write. The master also drives ones on `sdi` during the read data phase, which checks that `sdi` is ignored there and that only the low address bits decode.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } spi_op_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic sdi_s
);
  logic [STAGES-1:0] sclk_p, cs_p, sdi_p;
  logic              sclk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p    <= '0;
      cs_p      <= '1;
      sdi_p     <= '0;
      sclk_last <= 1'b0;
    end else begin
      sclk_p    <= {sclk_p[STAGES-2:0], sclk};
      cs_p      <= {cs_p[STAGES-2:0], cs_n};
      sdi_p     <= {sdi_p[STAGES-2:0], sdi};
      sclk_last <= sclk_p[STAGES-1];
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_last;
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_last;
  assign cs_act    = ~cs_p[STAGES-1];
  assign sdi_s     = sdi_p[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_port_pkg::*;
#(
  parameter int ADDR_FIELD = 15,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sdi_s,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  output logic              rd_data_phase
);
  localparam int HDR_BITS   = 1 + ADDR_FIELD;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int SH_W       = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;

  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  spi_op_e          op;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sh        <= '0;
      op        <= OP_WRITE;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else if (!cs_act) begin
      cnt    <= '0;
      op     <= OP_WRITE;
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (sclk_rise && cnt < CNT_W'(FRAME_BITS)) begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[SH_W-2:0], sdi_s};
        if (cnt == '0)
          op <= spi_op_e'(sdi_s);
        if (cnt == CNT_W'(HDR_BITS - 1)) begin
          reg_addr <= {sh[ADDR_W-2:0], sdi_s};
          if (op == OP_READ)
            reg_rd <= 1'b1;
        end
        if (cnt == CNT_W'(FRAME_BITS - 1) && op == OP_WRITE) begin
          reg_wdata <= {sh[DATA_W-2:0], sdi_s};
          reg_wr    <= 1'b1;
        end
      end
    end
  end

  assign rd_data_phase = (op == OP_READ) && (cnt >= CNT_W'(HDR_BITS));
endmodule

// File: rtl/spi_tx.sv
module spi_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sclk_fall,
  input  logic              rd_req,
  input  logic              rd_data_phase,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int LEFT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] tx;
  logic [LEFT_W-1:0] left;
  logic              rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      tx     <= '0;
      left   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (!cs_act) begin
      rd_q   <= 1'b0;
      left   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      rd_q <= rd_req;
      if (rd_q) begin
        tx   <= rdata;
        left <= LEFT_W'(DATA_W);
      end else if (sclk_fall && rd_data_phase && left != '0) begin
        sdo    <= tx[DATA_W-1];
        tx     <= {tx[DATA_W-2:0], 1'b0};
        left   <= left - 1'b1;
        sdo_oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_FIELD  = 15,
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic sclk_rise, sclk_fall, cs_act, sdi_s, rd_data_phase;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .sdi_s(sdi_s)
  );

  spi_frame_rx #(.ADDR_FIELD(ADDR_FIELD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_rise(sclk_rise), .sdi_s(sdi_s),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .rd_data_phase(rd_data_phase)
  );

  spi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .rd_req(reg_rd), .rd_data_phase(rd_data_phase), .rdata(reg_rdata),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic reg_wr,
  input logic reg_rd,
  input logic sdo_oe
);
  // R4: write strobe lasts one cycle
  p_wr_single_r4: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr);
  // R6: read request lasts one cycle
  p_rd_single_r6: assert property (@(posedge clk) disable iff (rst) reg_rd |=> !reg_rd);
  // R2: one frame is either a read or a write
  p_op_excl_r2: assert property (@(posedge clk) disable iff (rst) !(reg_wr && reg_rd));
  // R8: a write frame never enables the output
  p_wr_no_oe_r8: assert property (@(posedge clk) disable iff (rst) reg_wr |-> !sdo_oe);
  // R8: output released once chip select has been high for a while
  p_oe_release_r8: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);
  // R9: reset clears the strobes and the output enable
  p_reset_r9: assert property (@(posedge clk) rst |=> (!reg_wr && !reg_rd && !sdo_oe));
endmodule

bind spi_reg_port spi_port_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .sdo_oe(sdo_oe)
);

// File: tb/sim_spi_reg_port.sv
`timescale 1ns/1ps
module sim_spi_reg_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       sdi = 1'b0;
  logic       sdo, sdo_oe, reg_wr, reg_rd;
  logic [9:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata = 8'h00;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  spi_reg_port u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  // register file model with one clock of read latency
  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    if (reg_wr) mem[reg_addr] <= reg_wdata;
    if (reg_rd) reg_rdata <= mem[reg_addr];
  end

  // strobe monitor
  int         n_wr = 0, n_rd = 0;
  logic [9:0] last_wr_addr = '0, last_rd_addr = '0;
  logic [7:0] last_wdata = '0;
  always @(negedge clk) begin
    if (reg_wr) begin n_wr++; last_wr_addr = reg_addr; last_wdata = reg_wdata; end
    if (reg_rd) begin n_rd++; last_rd_addr = reg_addr; end
  end

  logic [7:0] exp_mem [0:1023];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  // frame = {op, addr15, data8}; nbits may differ from 24
  task automatic xfer(input logic [23:0] fr, input int nbits,
                      output logic [7:0] rd, output int oe_bad);
    bit is_rd;
    is_rd  = fr[23];
    rd     = '0;
    oe_bad = 0;
    @(negedge clk);
    cs_n = 1'b0;
    half();
    for (int i = 0; i < nbits; i++) begin
      if (is_rd && i >= 16) sdi = 1'b1;      // don't care during read data
      else sdi = (i < 24) ? fr[23 - i] : 1'b0;
      half();
      if (sdo_oe !== (is_rd && i >= 16)) oe_bad++;
      if (i >= 16 && i < 24) rd = {rd[6:0], sdo};
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
    half();
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 15'h7C05, 8'hA5},
    {1'b0, 15'h0000, 8'h3C},
    {1'b0, 15'h03FF, 8'h81},
    {1'b0, 15'h1234, 8'hFF},
    {1'b1, 15'h0005, 8'h5A},
    {1'b1, 15'h7C00, 8'h5A},
    {1'b1, 15'h6BFF, 8'h5A},
    {1'b1, 15'h0234, 8'h5A},
    {1'b1, 15'h0111, 8'h5A}
  };

  initial begin
    logic [7:0] rd;
    int oe_bad, w0, r0;
    for (int k = 0; k < 1024; k++) begin mem[k] = 8'h00; exp_mem[k] = 8'h00; end

    repeat (4) @(negedge clk);
    check(sdo_oe === 1'b0 && reg_wr === 1'b0 && reg_rd === 1'b0, "R9",
          "reset outputs", {sdo_oe, reg_wr, reg_rd}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1: clocks with chip select high do nothing
    w0 = n_wr; r0 = n_rd;
    for (int i = 0; i < 30; i++) begin
      sdi = i[0]; half(); sclk = 1'b1; half(); sclk = 1'b0;
    end
    check(n_wr == w0 && n_rd == r0 && sdo_oe == 1'b0, "R1", "activity while deselected",
          (n_wr - w0) + (n_rd - r0), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [23:0] fr;
      logic [9:0]  a;
      fr = VEC[v];
      a  = fr[17:8];
      w0 = n_wr; r0 = n_rd;
      xfer(fr, 24, rd, oe_bad);
      check(oe_bad == 0, "R8", "output enable timing", oe_bad, 0);
      if (!fr[23]) begin
        exp_mem[a] = fr[7:0];
        check(n_wr - w0 == 1 && n_rd == r0, "R2", "write strobe count", n_wr - w0, 1);
        check(last_wr_addr == a, "R3", "write address", last_wr_addr, a);
        check(last_wdata == fr[7:0], "R4", "write data", last_wdata, fr[7:0]);
      end else begin
        check(n_rd - r0 == 1 && n_wr == w0, "R6", "read request count", n_rd - r0, 1);
        check(last_rd_addr == a, "R3", "read address", last_rd_addr, a);
        check(rd == exp_mem[a], "R7", "read data", rd, exp_mem[a]);
      end
      check(sdo_oe == 1'b0, "R8", "released after frame", sdo_oe, 0);
    end

    // R5: write cut short by chip select
    w0 = n_wr;
    xfer({1'b0, 15'h0005, 8'h00}, 20, rd, oe_bad);
    check(n_wr == w0, "R5", "aborted write strobe", n_wr - w0, 0);
    xfer({1'b1, 15'h0005, 8'h00}, 24, rd, oe_bad);
    check(rd == 8'hA5, "R5", "register kept after abort", rd, 8'hA5);

    // R10: extra clocks after a full write
    w0 = n_wr;
    xfer({1'b0, 15'h0010, 8'h77}, 28, rd, oe_bad);
    check(n_wr - w0 == 1, "R10", "strobes with extra clocks", n_wr - w0, 1);
    check(last_wdata == 8'h77, "R10", "data with extra clocks", last_wdata, 8'h77);
    r0 = n_rd;
    xfer({1'b1, 15'h3810, 8'h00}, 28, rd, oe_bad);
    check(n_rd - r0 == 1, "R10", "read requests with extra clocks", n_rd - r0, 1);
    check(rd == 8'h77, "R7", "readback after long write", rd, 8'h77);
    check(oe_bad == 0, "R8", "output enable on long read", oe_bad, 0);

    // R9: reset mid-read releases the output
    @(negedge clk);
    cs_n = 1'b0;
    half();
    rst = 1'b1;
    @(negedge clk);
    check(sdo_oe == 1'b0 && reg_rd == 1'b0, "R9", "reset during frame", sdo_oe, 0);
    rst = 1'b0;
    cs_n = 1'b1;
    repeat (8) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule